// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the control and address lines of a synchronous DRAM interface on every rising clock edge. It turns the chip-select, RAS, CAS, WE and clock-enable levels into one command code. It also keeps the state of each bank: whether the bank is idle or active, which row is open, and whether an auto-precharge is pending. The decoded command is reported together with the bank, row and column it names. A one-cycle error pulse marks any command that breaks the access protocol. A rejected command leaves the bank state and the stored mode word unchanged.

It is meant to sit beside a memory controller or a memory model as a protocol monitor. It can also feed a controller's scheduler with the set of open rows. Data transfer, burst counting beyond the fixed auto-precharge length, and refresh-interval timing are handled elsewhere.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With `csN` high the reported code is 0 (inhibit), `errPulse` stays low, and no bank state or mode word changes, whatever the other lines carry.
- R2: With `csN` low, `{rasN,casN,weN}` decodes as follows, reported on `cmdCode`: 111 gives 1 (NOP), 011 gives 2 (ACTIVE), 101 gives 3 (READ), 100 gives 4 (WRITE), 110 gives 5 (burst stop), 010 gives 6 (PRECHARGE), 001 gives refresh, and 000 gives 9 (load mode). All outputs are registered and appear one clock after the edge that sampled the command.
- R3: A legal ACTIVE marks bank `bankSel` active, stores `addr[11:0]` as its open row in `openRows[b*12 +: 12]`, and reports the bank and row on `cmdBank` and `cmdRow`.
- R4: An ACTIVE to a bank that is already active raises `errPulse`, and that bank's open row stays unchanged.
- R5: A READ or WRITE to an idle bank raises `errPulse`. A legal READ or WRITE reports `addr[8:0]` on `cmdCol`, and `autoPre` equals `addr[10]`.
- R6: A legal READ or WRITE with `addr[10]` high closes its bank BURST_LEN (default 4) clocks after the command. The bank is still active after BURST_LEN-1 clocks.
- R7: PRECHARGE with `addr[10]` low closes only bank `bankSel`. With `addr[10]` high it closes every bank, and `bankSel` has no effect.
- R8: The refresh pattern reports 7 (auto refresh) when `cke` is high and 8 (self refresh) when `cke` is low. It raises `errPulse` if any bank is active.
- R9: Load mode is legal only when every bank is idle. A legal load mode stores `addr[11:0]` in `modeReg`. An illegal one raises `errPulse` and leaves `modeReg` as it was.
- R10: After a legal load mode, any command other than inhibit or NOP in the next TMRD-1 clocks (default 1) raises `errPulse` and is not applied. NOP in that window is not an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every input is sampled on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable; chooses the refresh type |
| bankSel | input | 2 | Bank select |
| addr | input | 12 | Row, column, op-code and bit-10 flag |
| cmdCode | output | 4 | Decoded command code |
| errPulse | output | 1 | Protocol violation for the sampled command |
| cmdBank | output | 2 | Bank named by the sampled command |
| cmdRow | output | 12 | Row field of the sampled command |
| cmdCol | output | 9 | Column field of the sampled command |
| autoPre | output | 1 | Legal READ/WRITE asked for auto-precharge |
| bankActive | output | 4 | One bit per bank, set while a row is open |
| openRows | output | 48 | Open row of each bank, bank 0 in the low bits |
| modeReg | output | 12 | Last op-code loaded legally |

## Verification
Every result is due one clock after the command is sampled. This covers the code, the fields, the error pulse, bank activity, open rows and the mode word. The bench changes the inputs on the falling edge and reads the outputs 1 ns after the next rising edge. The auto-precharge close is due BURST_LEN clocks after the READ or WRITE, so the bench issues NOPs and checks the bank after BURST_LEN-1 clocks and again after BURST_LEN clocks. The load-mode window is checked on the clock right after the load, once with an ACTIVE and once with a NOP.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [3:0] {
    CMD_INHIBIT = 4'd0,
    CMD_NOP     = 4'd1,
    CMD_ACTIVE  = 4'd2,
    CMD_READ    = 4'd3,
    CMD_WRITE   = 4'd4,
    CMD_BSTOP   = 4'd5,
    CMD_PRECH   = 4'd6,
    CMD_AREF    = 4'd7,
    CMD_SREF    = 4'd8,
    CMD_LMODE   = 4'd9
  } cmd_e;

  // strobes from control to the bank datapath, already gated by legality
  typedef struct packed {
    logic actEn;
    logic rdwrEn;
    logic apReq;
    logic preEn;
    logic preAll;
    logic lmrEn;
  } trk_strobe_t;

endpackage

// File: rtl/sdram_trk_ctrl.sv
module sdram_trk_ctrl
  import sdram_trk_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int TMRD   = 2,
  parameter int AP_BIT = 10,
  parameter int ADDR_W = 12,
  localparam int NUM_BANKS = 1 << BANK_W,
  localparam int MRD_W = $clog2(TMRD + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic                 cke,
  input  logic [BANK_W-1:0]    bankSel,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_BANKS-1:0] bankActive,
  output trk_strobe_t          strobe,
  output logic [3:0]           cmdCode,
  output logic                 errPulse
);

  cmd_e cmdNow;
  logic [MRD_W-1:0] mrdCnt;
  logic execCmd, mrdBusy, tgtActive, anyActive, errNow;

  always_comb begin
    unique casez ({csN, rasN, casN, weN})
      4'b1???: cmdNow = CMD_INHIBIT;
      4'b0111: cmdNow = CMD_NOP;
      4'b0011: cmdNow = CMD_ACTIVE;
      4'b0101: cmdNow = CMD_READ;
      4'b0100: cmdNow = CMD_WRITE;
      4'b0110: cmdNow = CMD_BSTOP;
      4'b0010: cmdNow = CMD_PRECH;
      4'b0001: cmdNow = cke ? CMD_AREF : CMD_SREF;
      default: cmdNow = CMD_LMODE;
    endcase
  end

  assign execCmd   = (cmdNow != CMD_INHIBIT) && (cmdNow != CMD_NOP);
  assign mrdBusy   = (mrdCnt != '0);
  assign tgtActive = bankActive[bankSel];
  assign anyActive = |bankActive;

  always_comb begin
    errNow = 1'b0;
    if (execCmd && mrdBusy) errNow = 1'b1;
    unique case (cmdNow)
      CMD_ACTIVE:                 if (tgtActive)  errNow = 1'b1;
      CMD_READ, CMD_WRITE:        if (!tgtActive) errNow = 1'b1;
      CMD_AREF, CMD_SREF, CMD_LMODE: if (anyActive) errNow = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    strobe        = '0;
    strobe.actEn  = (cmdNow == CMD_ACTIVE) && !errNow;
    strobe.rdwrEn = ((cmdNow == CMD_READ) || (cmdNow == CMD_WRITE)) && !errNow;
    strobe.apReq  = addr[AP_BIT];
    strobe.preEn  = (cmdNow == CMD_PRECH) && !errNow;
    strobe.preAll = addr[AP_BIT];
    strobe.lmrEn  = (cmdNow == CMD_LMODE) && !errNow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdCode  <= CMD_INHIBIT;
      errPulse <= 1'b0;
      mrdCnt   <= '0;
    end else begin
      cmdCode  <= cmdNow;
      errPulse <= errNow;
      if (strobe.lmrEn)  mrdCnt <= MRD_W'(TMRD - 1);
      else if (mrdBusy)  mrdCnt <= mrdCnt - 1'b1;
    end
  end

endmodule

// File: rtl/sdram_trk_bank_dp.sv
module sdram_trk_bank_dp
  import sdram_trk_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 9,
  parameter int BURST_LEN = 4,
  localparam int NUM_BANKS = 1 << BANK_W,
  localparam int BL_W = $clog2(BURST_LEN + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  trk_strobe_t                strobe,
  input  logic [BANK_W-1:0]          bankSel,
  input  logic [ROW_W-1:0]           addr,
  output logic [BANK_W-1:0]          cmdBank,
  output logic [ROW_W-1:0]           cmdRow,
  output logic [COL_W-1:0]           cmdCol,
  output logic                       autoPre,
  output logic [NUM_BANKS-1:0]       bankActive,
  output logic [NUM_BANKS*ROW_W-1:0] openRows,
  output logic [ROW_W-1:0]           modeReg
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic            hit, apPend, apFire;
    logic [BL_W-1:0] apCnt;

    assign hit    = (bankSel == BANK_W'(b));
    assign apFire = apPend && (apCnt == BL_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bankActive[b]             <= 1'b0;
        openRows[b*ROW_W +: ROW_W] <= '0;
        apPend                    <= 1'b0;
        apCnt                     <= '0;
      end else if (strobe.actEn && hit) begin
        bankActive[b]             <= 1'b1;
        openRows[b*ROW_W +: ROW_W] <= addr;
        apPend                    <= 1'b0;
      end else if ((strobe.preEn && (strobe.preAll || hit)) || apFire) begin
        bankActive[b] <= 1'b0;
        apPend        <= 1'b0;
      end else if (strobe.rdwrEn && strobe.apReq && hit) begin
        apPend <= 1'b1;
        apCnt  <= BL_W'(BURST_LEN);
      end else if (apPend) begin
        apCnt <= apCnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdBank <= '0;
      cmdRow  <= '0;
      cmdCol  <= '0;
      autoPre <= 1'b0;
      modeReg <= '0;
    end else begin
      cmdBank <= bankSel;
      cmdRow  <= addr;
      cmdCol  <= addr[COL_W-1:0];
      autoPre <= strobe.rdwrEn && strobe.apReq;
      if (strobe.lmrEn) modeReg <= addr;
    end
  end

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_trk_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 9,
  parameter int TMRD      = 2,
  parameter int BURST_LEN = 4,
  parameter int AP_BIT    = 10,
  localparam int NUM_BANKS = 1 << BANK_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       csN,
  input  logic                       rasN,
  input  logic                       casN,
  input  logic                       weN,
  input  logic                       cke,
  input  logic [BANK_W-1:0]          bankSel,
  input  logic [ROW_W-1:0]           addr,
  output logic [3:0]                 cmdCode,
  output logic                       errPulse,
  output logic [BANK_W-1:0]          cmdBank,
  output logic [ROW_W-1:0]           cmdRow,
  output logic [COL_W-1:0]           cmdCol,
  output logic                       autoPre,
  output logic [NUM_BANKS-1:0]       bankActive,
  output logic [NUM_BANKS*ROW_W-1:0] openRows,
  output logic [ROW_W-1:0]           modeReg
);

  trk_strobe_t strobe;

  sdram_trk_ctrl #(
    .BANK_W(BANK_W), .TMRD(TMRD), .AP_BIT(AP_BIT), .ADDR_W(ROW_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .cke(cke), .bankSel(bankSel), .addr(addr),
    .bankActive(bankActive), .strobe(strobe), .cmdCode(cmdCode),
    .errPulse(errPulse)
  );

  sdram_trk_bank_dp #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .BURST_LEN(BURST_LEN)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .bankSel(bankSel),
    .addr(addr), .cmdBank(cmdBank), .cmdRow(cmdRow), .cmdCol(cmdCol),
    .autoPre(autoPre), .bankActive(bankActive), .openRows(openRows),
    .modeReg(modeReg)
  );

endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  localparam int NUM_BANKS = 1 << BANK_W
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       csN,
  input logic                       rasN,
  input logic                       casN,
  input logic                       weN,
  input logic                       cke,
  input logic [BANK_W-1:0]          bankSel,
  input logic [ROW_W-1:0]           addr,
  input logic [3:0]                 cmdCode,
  input logic                       errPulse,
  input logic [BANK_W-1:0]          cmdBank,
  input logic [ROW_W-1:0]           cmdRow,
  input logic [COL_W-1:0]           cmdCol,
  input logic                       autoPre,
  input logic [NUM_BANKS-1:0]       bankActive,
  input logic [NUM_BANKS*ROW_W-1:0] openRows,
  input logic [ROW_W-1:0]           modeReg
);

  AST_INHIBIT_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdCode == 4'd0) |-> !errPulse); // R1

  AST_ACTIVE_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdCode == 4'd2 && !errPulse) |-> bankActive[cmdBank]); // R3

  AST_ACTIVE_ERR_KEEPS_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdCode == 4'd2 && errPulse) |-> (openRows == $past(openRows))); // R4

  AST_RDWR_ON_OPEN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmdCode == 4'd3 || cmdCode == 4'd4) && !errPulse) |-> bankActive[cmdBank]); // R5

  AST_AUTOPRE_ONLY_RDWR: assert property (@(posedge clk) disable iff (!rst_n)
    autoPre |-> (cmdCode == 4'd3 || cmdCode == 4'd4)); // R5

  AST_PRECH_ALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdCode == 4'd6 && !errPulse && cmdRow[10]) |-> (bankActive == '0)); // R7

  AST_REFRESH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmdCode == 4'd7 || cmdCode == 4'd8) && !errPulse) |-> (bankActive == '0)); // R8

  AST_LMODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdCode == 4'd9 && !errPulse) |-> (bankActive == '0 && modeReg == cmdRow)); // R9

endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(
  .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)
) u_chk (.*);

// File: tb/sdram_cmd_tracker_bench.sv
`timescale 1ns/1ps
module sdram_cmd_tracker_bench;

  localparam logic [3:0] C_INH  = 4'b1000;
  localparam logic [3:0] C_NOP  = 4'b0111;
  localparam logic [3:0] C_ACT  = 4'b0011;
  localparam logic [3:0] C_RD   = 4'b0101;
  localparam logic [3:0] C_WR   = 4'b0100;
  localparam logic [3:0] C_BST  = 4'b0110;
  localparam logic [3:0] C_PRE  = 4'b0010;
  localparam logic [3:0] C_REF  = 4'b0001;
  localparam logic [3:0] C_LMR  = 4'b0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1, cke = 1'b1;
  logic [1:0]  bankSel = '0;
  logic [11:0] addr = '0;
  logic [3:0]  cmdCode;
  logic        errPulse;
  logic [1:0]  cmdBank;
  logic [11:0] cmdRow;
  logic [8:0]  cmdCol;
  logic        autoPre;
  logic [3:0]  bankActive;
  logic [47:0] openRows;
  logic [11:0] modeReg;

  int nChecks = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;

  sdram_cmd_tracker u_sdram_cmd_tracker (
    .clk(clk), .rst_n(rst_n), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .cke(cke), .bankSel(bankSel), .addr(addr),
    .cmdCode(cmdCode), .errPulse(errPulse), .cmdBank(cmdBank),
    .cmdRow(cmdRow), .cmdCol(cmdCol), .autoPre(autoPre),
    .bankActive(bankActive), .openRows(openRows), .modeReg(modeReg)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive on falling edge, sample 1 ns after the rising edge that captures it
  task automatic issue(input logic [3:0] ctl, input logic [1:0] b,
                       input logic [11:0] a, input logic k);
    @(negedge clk);
    {csN, rasN, casN, weN} = ctl;
    bankSel = b; addr = a; cke = k;
    @(posedge clk);
    #1;
  endtask

  task automatic nop();
    issue(C_NOP, 2'd0, 12'd0, 1'b1);
  endtask

  task automatic t_reset();
    check("R1 reset code", cmdCode, 0);
    check("R1 reset banks", bankActive, 0);
    check("R1 reset err", errPulse, 0);
  endtask

  task automatic t_active();
    issue(C_ACT, 2'd1, 12'hABC, 1'b1);
    check("R2 ACTIVE code", cmdCode, 2);
    check("R3 err low", errPulse, 0);
    check("R3 bank set", bankActive, 4'b0010);
    check("R3 open row", openRows[12 +: 12], 12'hABC);
    check("R3 row field", cmdRow, 12'hABC);
    check("R3 bank field", cmdBank, 2'd1);
    issue(C_ACT, 2'd1, 12'h123, 1'b1);
    check("R4 double ACTIVE err", errPulse, 1);
    check("R4 row kept", openRows[12 +: 12], 12'hABC);
    nop();
    check("R4 err is one pulse", errPulse, 0);
  endtask

  task automatic t_rdwr();
    issue(C_RD, 2'd2, 12'h005, 1'b1);
    check("R5 READ idle err", errPulse, 1);
    issue(C_RD, 2'd1, 12'h1F5, 1'b1);
    check("R2 READ code", cmdCode, 3);
    check("R5 READ legal", errPulse, 0);
    check("R5 column", cmdCol, 9'h1F5);
    check("R5 no autopre", autoPre, 0);
    issue(C_BST, 2'd1, 12'h000, 1'b1);
    check("R2 burst stop code", cmdCode, 5);
    check("R5 bank stays open", bankActive, 4'b0010);
  endtask

  task automatic t_autopre();
    issue(C_WR, 2'd1, 12'h40A, 1'b1);
    check("R2 WRITE code", cmdCode, 4);
    check("R5 autopre flag", autoPre, 1);
    check("R5 write column", cmdCol, 9'h00A);
    for (int i = 0; i < 3; i++) nop();
    check("R6 open at BURST_LEN-1", bankActive[1], 1);
    nop();
    check("R6 closed at BURST_LEN", bankActive[1], 0);
  endtask

  task automatic t_precharge();
    issue(C_ACT, 2'd0, 12'h011, 1'b1);
    issue(C_ACT, 2'd3, 12'h033, 1'b1);
    check("R3 two banks", bankActive, 4'b1001);
    issue(C_PRE, 2'd0, 12'h000, 1'b1);
    check("R2 PRECHARGE code", cmdCode, 6);
    check("R7 single close", bankActive, 4'b1000);
    issue(C_ACT, 2'd2, 12'h022, 1'b1);
    issue(C_PRE, 2'd2, 12'h400, 1'b1);
    check("R7 precharge all", bankActive, 4'b0000);
  endtask

  task automatic t_refresh();
    issue(C_ACT, 2'd0, 12'h001, 1'b1);
    issue(C_REF, 2'd0, 12'h000, 1'b1);
    check("R8 refresh with open bank err", errPulse, 1);
    issue(C_PRE, 2'd0, 12'h400, 1'b1);
    issue(C_REF, 2'd0, 12'h000, 1'b1);
    check("R8 auto refresh code", cmdCode, 7);
    check("R8 auto refresh legal", errPulse, 0);
    issue(C_REF, 2'd0, 12'h000, 1'b0);
    check("R8 self refresh code", cmdCode, 8);
  endtask

  task automatic t_inhibit();
    issue(C_ACT, 2'd3, 12'h077, 1'b1);
    issue(C_INH | C_PRE, 2'd3, 12'h400, 1'b1);
    check("R1 inhibit code", cmdCode, 0);
    check("R1 inhibit no err", errPulse, 0);
    check("R1 inhibit no close", bankActive, 4'b1000);
    issue(C_INH | C_ACT, 2'd3, 12'h0EE, 1'b1);
    check("R1 inhibit row kept", openRows[36 +: 12], 12'h077);
  endtask

  task automatic t_lmode();
    issue(C_LMR, 2'd0, 12'h0F0, 1'b1);
    check("R9 load with open bank err", errPulse, 1);
    check("R9 mode kept", modeReg, 12'h000);
    issue(C_PRE, 2'd0, 12'h400, 1'b1);
    issue(C_LMR, 2'd0, 12'h032, 1'b1);
    check("R2 load code", cmdCode, 9);
    check("R9 load legal", errPulse, 0);
    check("R9 op-code", modeReg, 12'h032);
    issue(C_ACT, 2'd2, 12'h055, 1'b1);
    check("R10 ACTIVE in window err", errPulse, 1);
    check("R10 not applied", bankActive, 4'b0000);
    issue(C_ACT, 2'd2, 12'h055, 1'b1);
    check("R10 ACTIVE after window", errPulse, 0);
    check("R10 applied", bankActive, 4'b0100);
    issue(C_PRE, 2'd2, 12'h000, 1'b1);
    issue(C_LMR, 2'd0, 12'h021, 1'b1);
    nop();
    check("R10 NOP in window ok", errPulse, 0);
    issue(C_ACT, 2'd1, 12'h099, 1'b1);
    check("R10 ACTIVE after NOP ok", errPulse, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_active();
    t_rdwr();
    t_autopre();
    t_precharge();
    t_refresh();
    t_inhibit();
    t_lmode();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule